// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock for an I2C master and the two timing strobes a byte engine needs to drive and read the data line. It runs from one input clock. A 32-bit configuration word carries two 16-bit divisors, one for the low phase of SCL and one for the high phase. Each phase lasts the divisor plus one, times a fixed prescale of eight input cycles, so the duty cycle can be tuned per bus speed. Standard mode (100 kHz, at least 4.7 us low and 4.0 us high) and fast mode (400 kHz, at least 1.3 us low and 0.6 us high) are both reached by picking the two divisors.

The data line is never moved at the falling edge of SCL. Instead, a change strobe fires half-way through each low phase, and the block drives `sda_o` from `bit_in` on the following cycle. This makes the data hold time half the low period. A sample strobe fires half-way through each high phase, where a receiver should read SDA.

The byte engine starts a transfer with `start_req` and ends it with `stop_req`. The block then sequences the START condition (SDA falls while SCL is high) and the STOP condition (SDA rises while SCL is high). A divisor written while the bus runs is taken up only when the next low phase begins.

Top module: `i2c_scl_gen`

## Requirements
- R1: `div_cfg[15:0]` is the low-phase divisor L and `div_cfg[31:16]` is the high-phase divisor H; the two fields act independently.
- R2: Every SCL low phase lasts exactly 8*(L+1) input clock cycles, so L = 0 gives 8 cycles.
- R3: Every SCL high phase of a data bit lasts exactly 8*(H+1) input clock cycles, so H = 0 gives 8 cycles.
- R4: In a low phase that carries data, `sda_change_stb` is high for exactly one cycle, at cycle offset 4*(L+1) counted from 0 at the first low cycle. From the next cycle `sda_o` equals the `bit_in` value present in the strobe cycle. `sda_o` does not change during a data high phase.
- R5: In a data high phase, `sda_sample_stb` is high for exactly one cycle, at offset 4*(H+1). The two strobes are never high together, and neither is high in the wrong SCL level.
- R6: After synchronous reset, and whenever `bus_active` is 0, `scl_o` = 1, `sda_o` = 1 and both strobes are 0.
- R7: A `start_req` sampled high while idle and enabled makes `bus_active` 1 from the next cycle. `sda_o` = 0 and `scl_o` = 1 for 8*(H+1) cycles, and then SCL falls.
- R8: The divisors are captured at each START and at each entry into a low phase. A change of `div_cfg` during a phase has no effect on that phase. It only affects phases that begin after the next low-phase entry.
- R9: A `stop_req` sampled while active is acted on at the first low-phase midpoint that follows. There `sda_o` is driven 0 with no change strobe. A high phase of 8*(H+1) cycles then follows, with no sample strobe. In it `sda_o` rises at offset 4*(H+1)+1, and then the bus goes idle.
- R10: While `enable` is 0 the block returns to idle on the next cycle and stays there, and `start_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run enable; low forces idle |
| div_cfg | input | 32 | High divisor in bits 31:16, low divisor in bits 15:0 |
| start_req | input | 1 | Request a START condition |
| stop_req | input | 1 | Request a STOP condition |
| bit_in | input | 1 | Next data bit from the byte engine |
| scl_o | output | 1 | Serial clock level |
| sda_o | output | 1 | Data line level |
| sda_change_stb | output | 1 | One-cycle pulse: SDA takes `bit_in` next cycle |
| sda_sample_stb | output | 1 | One-cycle pulse: SDA should be sampled |
| bus_active | output | 1 | A transfer is in progress |

## Verification
A wrong phase counter or divisor selection shows at the ports within a single phase. SCL stays low or high for a run length that differs from 8*(divisor+1), and the strobes land at a different offset than half of that. A wrong capture moment for the divisor is exposed in the first phase after a mid-transfer rewrite of `div_cfg`. A wrong stop flag shows within one low phase: either a change strobe appears where SDA should have been pulled low, or SDA rises at the wrong moment of the final high phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

   // Bus sequencing phases of the SCL generator
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_LOW   = 3'd2,
      PH_HIGH  = 3'd3,
      PH_STOP  = 3'd4
   } phase_e;

   // Fixed prescale exponent: each divisor step is 2**PRESCALE_LOG2 cycles
   localparam int unsigned PRESCALE_LOG2 = 3;

endpackage

// File: rtl/sclgen_div_shadow.sv
// Holds the divisor pair in use; reloaded only at phase boundaries
module sclgen_div_shadow #(
   parameter int unsigned DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [2*DIV_W-1:0] cfg,
   output logic [DIV_W-1:0]   div_low,
   output logic [DIV_W-1:0]   div_high
);

   localparam int unsigned LO_LSB = 0;
   localparam int unsigned HI_LSB = DIV_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_low  <= '0;
         div_high <= '0;
      end else if (load) begin
         div_low  <= cfg[LO_LSB +: DIV_W];
         div_high <= cfg[HI_LSB +: DIV_W];
      end
   end

endmodule

// File: rtl/sclgen_phase_timer.sv
// Counts one SCL phase of (div+1)*2**PRE_LOG2 cycles; flags midpoint and end
module sclgen_phase_timer #(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned PRE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             at_mid,
   output logic             at_last
);

   localparam int unsigned CNT_W = DIV_W + PRE_LOG2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_v;
   logic [CNT_W-1:0] mid_v;

   // last count of the phase: (div+1)*2**PRE_LOG2 - 1
   assign last_v = {div, {PRE_LOG2{1'b1}}};
   // half of the phase length: (div+1)*2**(PRE_LOG2-1)
   assign mid_v  = ({{PRE_LOG2{1'b0}}, div} + CNT_W'(1)) << (PRE_LOG2 - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign at_last = (cnt_q == last_v);
   assign at_mid  = (cnt_q == mid_v);

endmodule

// File: rtl/sclgen_sequencer.sv
// Phase state machine: START, data low/high phases, STOP, and the line levels
module sclgen_sequencer
   import sclgen_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   enable,
   input  logic   start_req,
   input  logic   stop_req,
   input  logic   bit_in,
   input  logic   at_mid,
   input  logic   at_last,
   output phase_e phase,
   output logic   scl_o,
   output logic   sda_o,
   output logic   chg_stb,
   output logic   smp_stb,
   output logic   active,
   output logic   sel_high,
   output logic   load_div,
   output logic   tmr_clr
);

   phase_e phase_q, phase_d;
   logic   sda_q, sda_d;
   logic   scl_q;
   logic   pend_q, pend_d;   // stop requested, not yet acted on
   logic   arm_q, arm_d;     // current low phase prepares the STOP

   always_comb begin
      phase_d = phase_q;
      sda_d   = sda_q;
      pend_d  = pend_q;
      arm_d   = arm_q;

      if (stop_req && (phase_q inside {PH_START, PH_LOW, PH_HIGH})) begin
         pend_d = 1'b1;
      end

      unique case (phase_q)
         PH_IDLE: begin
            if (start_req) begin
               phase_d = PH_START;
               sda_d   = 1'b0;
            end
         end
         PH_START: begin
            if (at_last) phase_d = PH_LOW;
         end
         PH_LOW: begin
            if (at_mid) begin
               if (pend_q) begin
                  arm_d = 1'b1;
                  sda_d = 1'b0;
               end else begin
                  sda_d = bit_in;
               end
            end
            if (at_last) begin
               if (arm_q) begin
                  phase_d = PH_STOP;
                  pend_d  = 1'b0;
                  arm_d   = 1'b0;
               end else begin
                  phase_d = PH_HIGH;
               end
            end
         end
         PH_HIGH: begin
            if (at_last) phase_d = PH_LOW;
         end
         PH_STOP: begin
            if (at_mid)  sda_d   = 1'b1;
            if (at_last) phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase

      if (!enable) begin
         phase_d = PH_IDLE;
         sda_d   = 1'b1;
         pend_d  = 1'b0;
         arm_d   = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sda_q   <= 1'b1;
         scl_q   <= 1'b1;
         pend_q  <= 1'b0;
         arm_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         sda_q   <= sda_d;
         scl_q   <= (phase_d != PH_LOW);
         pend_q  <= pend_d;
         arm_q   <= arm_d;
      end
   end

   assign phase    = phase_q;
   assign scl_o    = scl_q;
   assign sda_o    = sda_q;
   assign active   = (phase_q != PH_IDLE);
   assign sel_high = (phase_q != PH_LOW);
   assign chg_stb  = (phase_q == PH_LOW) && at_mid && !pend_q;
   assign smp_stb  = (phase_q == PH_HIGH) && at_mid;
   assign tmr_clr  = (phase_q == PH_IDLE) || at_last || !enable;
   assign load_div = ((phase_q == PH_IDLE) && (phase_d == PH_START)) ||
                     (at_last && ((phase_q == PH_START) || (phase_q == PH_HIGH)));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
   import sclgen_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned PRE_LOG2 = PRESCALE_LOG2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [2*DIV_W-1:0] div_cfg,
   input  logic               start_req,
   input  logic               stop_req,
   input  logic               bit_in,
   output logic               scl_o,
   output logic               sda_o,
   output logic               sda_change_stb,
   output logic               sda_sample_stb,
   output logic               bus_active
);

   // elaboration-time parameter checks
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
         $error("i2c_scl_gen: DIV_W must be 1..16");
      end
      if (PRE_LOG2 < 1) begin : g_bad_pre
         $error("i2c_scl_gen: PRE_LOG2 must be at least 1 for a midpoint");
      end
   endgenerate

   phase_e           phase;
   logic [DIV_W-1:0] div_low, div_high, tmr_div;
   logic             sel_high, load_div, tmr_clr, at_mid, at_last;

   sclgen_div_shadow #(.DIV_W(DIV_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_div),
      .cfg      (div_cfg),
      .div_low  (div_low),
      .div_high (div_high)
   );

   assign tmr_div = sel_high ? div_high : div_low;

   sclgen_phase_timer #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .div     (tmr_div),
      .at_mid  (at_mid),
      .at_last (at_last)
   );

   sclgen_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .start_req (start_req),
      .stop_req  (stop_req),
      .bit_in    (bit_in),
      .at_mid    (at_mid),
      .at_last   (at_last),
      .phase     (phase),
      .scl_o     (scl_o),
      .sda_o     (sda_o),
      .chg_stb   (sda_change_stb),
      .smp_stb   (sda_sample_stb),
      .active    (bus_active),
      .sel_high  (sel_high),
      .load_div  (load_div),
      .tmr_clr   (tmr_clr)
   );

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic bit_in,
   input logic scl_o,
   input logic sda_o,
   input logic sda_change_stb,
   input logic sda_sample_stb,
   input logic bus_active
);

   p_chg_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sda_change_stb |-> !scl_o);

   p_chg_takes_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sda_change_stb) && $past(enable)) |-> (sda_o == $past(bit_in)));

   p_sda_still_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && bus_active && $past(bus_active)) |-> !$fell(sda_o));

   p_smp_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_sample_stb |-> scl_o);

   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sda_change_stb && sda_sample_stb));

   p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_active |-> (scl_o && sda_o && !sda_change_stb && !sda_sample_stb));

   p_start_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_active) |-> (scl_o && !sda_o));

   p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !bus_active);

endmodule

bind i2c_scl_gen sclgen_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .bit_in         (bit_in),
   .scl_o          (scl_o),
   .sda_o          (sda_o),
   .sda_change_stb (sda_change_stb),
   .sda_sample_stb (sda_sample_stb),
   .bus_active     (bus_active)
);

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] div_cfg = '0;
   logic        start_req = 1'b0;
   logic        stop_req = 1'b0;
   logic        bit_in = 1'b0;
   logic        scl_o, sda_o, sda_change_stb, sda_sample_stb, bus_active;

   always #5 clk = ~clk;

   i2c_scl_gen u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable         (enable),
      .div_cfg        (div_cfg),
      .start_req      (start_req),
      .stop_req       (stop_req),
      .bit_in         (bit_in),
      .scl_o          (scl_o),
      .sda_o          (sda_o),
      .sda_change_stb (sda_change_stb),
      .sda_sample_stb (sda_sample_stb),
      .bus_active     (bus_active)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int plen(input int d);
      return 8 * (d + 1);
   endfunction

   function automatic int pmid(input int d);
      return 4 * (d + 1);
   endfunction

   // divisor value present at the last rising edge (what a capture would see)
   logic [31:0] div_seen = '0;
   always @(posedge clk) div_seen <= div_cfg;

   // port monitor: 0 idle, 1 start, 2 low, 3 high, 4 stop-high
   int ph = 0, run = 0, n_chg = 0, off_chg = -1, n_smp = 0, off_smp = -1, off_rise = -1;
   int el = 0, eh = 0, hi_count = 0;
   bit sda0 = 1'b1, moved = 1'b0, exp_sda = 1'b0;
   bit prev_scl = 1'b1, prev_act = 1'b0, abort = 1'b0, stop_asked = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!bus_active) begin
            if (ph == 4) begin
               chk("R9 stop high length", run, plen(eh));
               chk("R9 sda rise offset", off_rise, pmid(eh) + 1);
               chk("R9 no sample strobe in stop", n_smp, 0);
               chk("R9 lines released", {scl_o, sda_o}, 3);
            end else if (ph != 0 && !abort) begin
               chk("R9 unexpected bus release", ph, 0);
            end
            ph = 0;
            stop_asked = 1'b0;
         end else if (!prev_act) begin
            ph = 1;
            el = int'(div_seen[15:0]);
            eh = int'(div_seen[31:16]);
            chk("R7 start scl high sda low", {scl_o, sda_o}, 2);
            run = 0;
         end else if (scl_o != prev_scl) begin
            if (!scl_o) begin
               if (ph == 1) begin
                  chk("R1 R7 start hold length", run, plen(eh));
                  chk("R7 sda held low in start", moved, 0);
               end else if (ph == 3) begin
                  chk("R1 R3 R8 high length", run, plen(eh));
                  chk("R5 sample strobe count", n_smp, 1);
                  chk("R5 sample strobe offset", off_smp, pmid(eh));
                  chk("R4 sda stable in high", moved, 0);
               end else begin
                  chk("R2 unexpected scl fall", ph, 3);
               end
               el = int'(div_seen[15:0]);
               eh = int'(div_seen[31:16]);
               ph = 2;
            end else begin
               if (ph == 2) begin
                  chk("R1 R2 R8 low length", run, plen(el));
                  if (n_chg == 0) begin
                     chk("R9 stop prep only on request", stop_asked, 1);
                     chk("R9 sda low before stop", sda_o, 0);
                     ph = 4;
                  end else begin
                     chk("R4 change strobe count", n_chg, 1);
                     chk("R4 change strobe offset", off_chg, pmid(el));
                     chk("R4 sda follows bit_in", sda_o, exp_sda);
                     ph = 3;
                  end
                  hi_count++;
               end else begin
                  chk("R3 unexpected scl rise", ph, 2);
               end
            end
            run = 0;
         end
         if (bus_active) begin
            if (run == 0) begin
               sda0 = sda_o; moved = 1'b0;
               n_chg = 0; n_smp = 0; off_chg = -1; off_smp = -1; off_rise = -1;
            end
            if (sda_change_stb) begin
               n_chg++;
               off_chg = run;
               bit_in = 1'($urandom_range(0, 1));
               exp_sda = bit_in;
            end
            if (sda_sample_stb) begin
               n_smp++;
               off_smp = run;
            end
            if (sda_o != sda0) begin
               moved = 1'b1;
               if (ph == 4 && off_rise < 0) off_rise = run;
            end
            run++;
         end
      end
      prev_scl = scl_o;
      prev_act = bus_active;
   end

   task automatic run_xfer(input int dl, input int dh, input int nbits, input bit chg_mid);
      @(negedge clk);
      div_cfg   = {dh[15:0], dl[15:0]};
      start_req = 1'b1;
      hi_count  = 0;
      @(negedge clk);
      start_req = 1'b0;
      while (hi_count < nbits) @(negedge clk);
      if (chg_mid) begin
         repeat (3) @(negedge clk);
         // R8: rewrite while a phase is running
         div_cfg = {16'($urandom_range(0, 9)), 16'($urandom_range(0, 9))};
      end
      @(negedge clk);
      stop_req   = 1'b1;
      stop_asked = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      while (bus_active) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R6 idle scl after stop", scl_o, 1);
      chk("R6 idle sda after stop", sda_o, 1);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk("watchdog expired", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      chk("R6 reset scl", scl_o, 1);
      chk("R6 reset sda", sda_o, 1);
      chk("R6 reset active", bus_active, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 idle strobes", {sda_change_stb, sda_sample_stb}, 0);

      // R10: start ignored while disabled
      start_req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R10 start ignored when disabled", bus_active, 0);
      end
      start_req = 1'b0;
      enable = 1'b1;
      @(negedge clk);

      // directed corners
      run_xfer(0, 0, 3, 1'b0);
      run_xfer(0, 3, 2, 1'b0);
      run_xfer(7, 1, 4, 1'b0);
      run_xfer(2, 5, 3, 1'b1);
      run_xfer(1, 2, 0, 1'b0);   // stop during START

      // R10: abort a running transfer
      @(negedge clk);
      div_cfg = {16'd2, 16'd2};
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (40) @(negedge clk);
      abort  = 1'b1;
      enable = 1'b0;
      @(negedge clk);
      chk("R10 disable forces idle", bus_active, 0);
      chk("R10 disable releases lines", {scl_o, sda_o}, 3);
      chk("R10 disable clears strobes", {sda_change_stb, sda_sample_stb}, 0);
      @(negedge clk);
      enable = 1'b1;
      abort  = 1'b0;
      @(negedge clk);

      // constrained random transfers
      for (int k = 0; k < 16; k++) begin
         run_xfer(int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                  int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)));
      end

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule